// File: doc/BRIEF.md
# Self-Clearing Transfer Command Register

This block is the command and control register of a serial bus link controller. Its 16 bits hold four plain enable bits and four command bits. Software sets a command bit to ask for an action: send the transmit buffer, send an in-frame response, send a break symbol, or release the receive buffer after reading it. The hardware partner clears the bit when that action completes. If software clears a transmit or response bit while its transfer is still running, the block aborts that transfer.

The block turns command-bit changes into one-cycle start and abort strobes for the transmit engine. It presents the break and release bits as level requests. It keeps a CPU-side transmit ownership flag, which it drops whenever the transmit request goes back to zero. It also latches which source supplies the in-frame response: the dedicated response register or the transmit buffer. The latch is taken when the response is started, from the enable bit and the response type in force at that moment.

Top module: `xfer_cmd_reg`

## Requirements
- R1: After synchronous reset the register reads 0x0000, all strobes and flags are 0, and bits 15..8 always read 0.
- R2: Bits 7 (receive interrupt enable), 6 (transmit interrupt enable), 5 (response register enable) and 4 (CRC enable) are plain read/write bits, updated by every write.
- R3: A write that changes bit 1 (transmit request) from 0 to 1 sets it and pulses `tx_start` for one cycle in the cycle after the write. Writing 1 while the bit is already 1 gives no pulse.
- R4: `tx_done` clears bit 1 at the next clock edge.
- R5: A write of 0 to bit 1 while it is 1 and no completion arrives in that cycle pulses `tx_abort` for one cycle. Clearing an idle bit gives no pulse.
- R6: `own_set` sets `own_flag`. In any cycle where bit 1 goes from 1 to 0, `own_flag` is cleared, and this clear wins over `own_set`.
- R7: `rsp_start` pulses only after a 0-to-1 write of bit 0. Setting bit 1 never starts a response.
- R8: Bit 0 (response request) follows the same rules as bit 1, using `rsp_start`, `rsp_abort` and `rsp_done`.
- R9: When bit 0 rises, `rsp_src_reg` latches 1 if the written bit 5 is 1, `rsp_type` is 1 or 2 and `rsp_hdr3` is 0. Otherwise it latches 0 (transmit buffer). It holds while the response runs.
- R10: Bit 3 (break) drives `brk_req` and is cleared by `brk_done`. Bit 2 (receive buffer read out) drives `rel_req` and is cleared by `rel_done`. Neither bit has strobes.
- R11: If a completion input and a write to the same command bit fall in the same cycle, the bit ends at 0, the write is ignored and no strobe is produced.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| wr_en | input | 1 | CPU write strobe |
| wr_data | input | 16 | CPU write data |
| rd_data | output | 16 | Register read value |
| rsp_type | input | 2 | Current in-frame response type |
| rsp_hdr3 | input | 1 | Three-byte consolidated header in use |
| tx_done | input | 1 | Transmit completed successfully |
| rsp_done | input | 1 | Response completed successfully |
| rel_done | input | 1 | Receive buffer released |
| brk_done | input | 1 | Break symbol sent |
| own_set | input | 1 | CPU takes ownership of transmit buffer |
| tx_start | output | 1 | One-cycle transmit start |
| tx_abort | output | 1 | One-cycle transmit abort |
| rsp_start | output | 1 | One-cycle response start |
| rsp_abort | output | 1 | One-cycle response abort |
| brk_req | output | 1 | Break request level |
| rel_req | output | 1 | Receive buffer release request level |
| own_flag | output | 1 | CPU-side transmit ownership flag |
| rsp_src_reg | output | 1 | 1 = response from response register, 0 = from transmit buffer |
| rx_ie | output | 1 | Receive interrupt enable |
| tx_ie | output | 1 | Transmit interrupt enable |
| crc_en | output | 1 | CRC enable |

## Verification
The hardest case to reach is the same-cycle collision: a completion pulse lands in exactly the cycle of a software write to the same bit. This has to be checked both when the write sets the bit and when it clears a busy bit. Directed steps raise the completion input together with the write at one negative edge. A long stretch of random writes and completion pulses then recreates the collision many times, and a per-cycle reference model checks the resulting bit, strobes and ownership flag.

// File: rtl/xfer_cmd_pkg.sv
package xfer_cmd_pkg;

    localparam int CMD_N   = 4;
    localparam int CFG_N   = 4;
    localparam int CMD_RSP = 0;
    localparam int CMD_TX  = 1;
    localparam int CMD_REL = 2;
    localparam int CMD_BRK = 3;
    localparam int CFG_LSB = CMD_N;
    localparam int RSP_EN_BIT = 5;

    typedef enum logic {
        SRC_TXBUF  = 1'b0,
        SRC_RSPREG = 1'b1
    } rsp_src_e;

    typedef struct packed {
        logic rx_ie;
        logic tx_ie;
        logic rsp_en;
        logic crc_en;
    } cfg_t;

    function automatic rsp_src_e pick_rsp_src(input logic en,
                                              input logic [1:0] ty,
                                              input logic hdr3);
        if (en && (ty == 2'd1 || ty == 2'd2) && !hdr3)
            return SRC_RSPREG;
        return SRC_TXBUF;
    endfunction

endpackage

// File: rtl/xfer_cmd_bit.sv
module xfer_cmd_bit #(
    parameter bit STROBES = 1'b1
) (
    input  logic clk,
    input  logic rst,
    input  logic wr_en,
    input  logic wr_val,
    input  logic hw_clr,
    output logic bit_q,
    output logic bit_d,
    output logic start_p,
    output logic abort_p
);

    logic rise_c;
    logic drop_c;

    always_comb begin
        if (hw_clr)
            bit_d = 1'b0;
        else if (wr_en)
            bit_d = wr_val;
        else
            bit_d = bit_q;
    end

    assign rise_c = bit_d & ~bit_q;
    assign drop_c = wr_en & ~wr_val & bit_q & ~hw_clr;

    always_ff @(posedge clk) begin
        if (rst)
            bit_q <= 1'b0;
        else
            bit_q <= bit_d;
    end

    generate
        if (STROBES) begin : g_strobe
            always_ff @(posedge clk) begin
                if (rst) begin
                    start_p <= 1'b0;
                    abort_p <= 1'b0;
                end else begin
                    start_p <= rise_c;
                    abort_p <= drop_c;
                end
            end

            // R3 / R8: a start pulse only follows a fresh rise of the bit
            a_r3_start_on_rise: assert property (@(posedge clk) disable iff (rst)
                start_p |-> (bit_q && !$past(bit_q)));

            // R5 / R8: an abort pulse only follows a software drop of a busy bit
            a_r5_abort_on_drop: assert property (@(posedge clk) disable iff (rst)
                abort_p |-> (!bit_q && $past(bit_q) && !$past(hw_clr)));
        end else begin : g_level
            logic unused_edges;
            assign unused_edges = rise_c ^ drop_c;
            assign start_p = 1'b0;
            assign abort_p = 1'b0;
        end
    endgenerate

    // R11: completion always wins over a same-cycle write
    a_r11_hw_wins: assert property (@(posedge clk) disable iff (rst)
        hw_clr |=> !bit_q);

endmodule

// File: rtl/xfer_rsp_src.sv
module xfer_rsp_src
    import xfer_cmd_pkg::*;
(
    input  logic       clk,
    input  logic       rst,
    input  logic       rise,
    input  logic       en_now,
    input  logic [1:0] ty,
    input  logic       hdr3,
    input  logic       busy,
    output rsp_src_e   src_q
);

    always_ff @(posedge clk) begin
        if (rst)
            src_q <= SRC_TXBUF;
        else if (rise)
            src_q <= pick_rsp_src(en_now, ty, hdr3);
    end

    // R9: source held constant while the response keeps running
    a_r9_src_held: assert property (@(posedge clk) disable iff (rst)
        (busy && $past(busy)) |-> $stable(src_q));

endmodule

// File: rtl/xfer_cmd_reg.sv
module xfer_cmd_reg
    import xfer_cmd_pkg::*;
#(
    parameter int REG_W = 16
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             wr_en,
    input  logic [REG_W-1:0] wr_data,
    output logic [REG_W-1:0] rd_data,
    input  logic [1:0]       rsp_type,
    input  logic             rsp_hdr3,
    input  logic             tx_done,
    input  logic             rsp_done,
    input  logic             rel_done,
    input  logic             brk_done,
    input  logic             own_set,
    output logic             tx_start,
    output logic             tx_abort,
    output logic             rsp_start,
    output logic             rsp_abort,
    output logic             brk_req,
    output logic             rel_req,
    output logic             own_flag,
    output logic             rsp_src_reg,
    output logic             rx_ie,
    output logic             tx_ie,
    output logic             crc_en
);

    localparam int LOW_W = CMD_N + CFG_N;
    localparam int HI_W  = REG_W - LOW_W;

    logic [CMD_N-1:0] cmd_q, cmd_d, start_v, abort_v, done_v;
    cfg_t             cfg_q;
    rsp_src_e         src_q;
    logic             own_q;
    logic             tx_fall;

    assign done_v[CMD_RSP] = rsp_done;
    assign done_v[CMD_TX]  = tx_done;
    assign done_v[CMD_REL] = rel_done;
    assign done_v[CMD_BRK] = brk_done;

    generate
        for (genvar i = 0; i < CMD_N; i++) begin : g_cmd
            localparam bit HAS_STROBE = (i == CMD_RSP) || (i == CMD_TX);
            xfer_cmd_bit #(.STROBES(HAS_STROBE)) u_bit (
                .clk     (clk),
                .rst     (rst),
                .wr_en   (wr_en),
                .wr_val  (wr_data[i]),
                .hw_clr  (done_v[i]),
                .bit_q   (cmd_q[i]),
                .bit_d   (cmd_d[i]),
                .start_p (start_v[i]),
                .abort_p (abort_v[i])
            );
        end
    endgenerate

    always_ff @(posedge clk) begin
        if (rst)
            cfg_q <= '0;
        else if (wr_en)
            cfg_q <= cfg_t'(wr_data[CFG_LSB +: CFG_N]);
    end

    assign tx_fall = cmd_q[CMD_TX] & ~cmd_d[CMD_TX];

    always_ff @(posedge clk) begin
        if (rst)
            own_q <= 1'b0;
        else if (tx_fall)
            own_q <= 1'b0;
        else if (own_set)
            own_q <= 1'b1;
    end

    xfer_rsp_src u_src (
        .clk    (clk),
        .rst    (rst),
        .rise   (cmd_d[CMD_RSP] & ~cmd_q[CMD_RSP]),
        .en_now (wr_data[RSP_EN_BIT]),
        .ty     (rsp_type),
        .hdr3   (rsp_hdr3),
        .busy   (cmd_q[CMD_RSP]),
        .src_q  (src_q)
    );

    logic unused_bits;
    assign unused_bits = ^{wr_data[REG_W-1:LOW_W], start_v[CMD_BRK:CMD_REL],
                           abort_v[CMD_BRK:CMD_REL]};

    assign rd_data     = {{HI_W{1'b0}}, cfg_q, cmd_q};
    assign tx_start    = start_v[CMD_TX];
    assign tx_abort    = abort_v[CMD_TX];
    assign rsp_start   = start_v[CMD_RSP];
    assign rsp_abort   = abort_v[CMD_RSP];
    assign brk_req     = cmd_q[CMD_BRK];
    assign rel_req     = cmd_q[CMD_REL];
    assign own_flag    = own_q;
    assign rsp_src_reg = (src_q == SRC_RSPREG);
    assign rx_ie       = cfg_q.rx_ie;
    assign tx_ie       = cfg_q.tx_ie;
    assign crc_en      = cfg_q.crc_en;

    // R6: ownership gone once the transmit request has dropped
    a_r6_own_cleared: assert property (@(posedge clk) disable iff (rst)
        $fell(cmd_q[CMD_TX]) |-> !own_q);

    // R7: a response start is only caused by a write of bit 0
    a_r7_rsp_from_bit0: assert property (@(posedge clk) disable iff (rst)
        rsp_start |-> $past(wr_en && wr_data[CMD_RSP]));

endmodule

// File: tb/tb_xfer_cmd_reg.sv
`timescale 1ns/1ps
module tb_xfer_cmd_reg;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        wr_en = 1'b0;
    logic [15:0] wr_data = '0;
    logic [15:0] rd_data;
    logic [1:0]  rsp_type = '0;
    logic        rsp_hdr3 = 1'b0;
    logic        tx_done = 1'b0, rsp_done = 1'b0, rel_done = 1'b0, brk_done = 1'b0;
    logic        own_set = 1'b0;
    logic        tx_start, tx_abort, rsp_start, rsp_abort;
    logic        brk_req, rel_req, own_flag, rsp_src_reg, rx_ie, tx_ie, crc_en;

    int n_chk = 0;
    int n_bad = 0;
    bit finished = 1'b0;

    always #2 clk = ~clk;

    xfer_cmd_reg dut (
        .clk(clk), .rst(rst), .wr_en(wr_en), .wr_data(wr_data), .rd_data(rd_data),
        .rsp_type(rsp_type), .rsp_hdr3(rsp_hdr3), .tx_done(tx_done),
        .rsp_done(rsp_done), .rel_done(rel_done), .brk_done(brk_done),
        .own_set(own_set), .tx_start(tx_start), .tx_abort(tx_abort),
        .rsp_start(rsp_start), .rsp_abort(rsp_abort), .brk_req(brk_req),
        .rel_req(rel_req), .own_flag(own_flag), .rsp_src_reg(rsp_src_reg),
        .rx_ie(rx_ie), .tx_ie(tx_ie), .crc_en(crc_en)
    );

    // behavioural reference, per-bit integer state
    int m_cmd[4];
    int m_cfg[4];
    int m_txs, m_txa, m_rss, m_rsa, m_own, m_src;

    always @(posedge clk) begin
        int done[4];
        int nb[4];
        int rise[4];
        int drop[4];
        done[0] = rsp_done; done[1] = tx_done; done[2] = rel_done; done[3] = brk_done;
        if (rst) begin
            foreach (m_cmd[k]) m_cmd[k] = 0;
            foreach (m_cfg[k]) m_cfg[k] = 0;
            m_txs = 0; m_txa = 0; m_rss = 0; m_rsa = 0; m_own = 0; m_src = 0;
        end else begin
            for (int k = 0; k < 4; k++) begin
                if (done[k] != 0) nb[k] = 0;
                else if (wr_en) nb[k] = wr_data[k];
                else nb[k] = m_cmd[k];
                rise[k] = (nb[k] == 1 && m_cmd[k] == 0) ? 1 : 0;
                drop[k] = (wr_en && wr_data[k] == 1'b0 && m_cmd[k] == 1 && done[k] == 0) ? 1 : 0;
            end
            m_txs = rise[1]; m_txa = drop[1];
            m_rss = rise[0]; m_rsa = drop[0];
            if (m_cmd[1] == 1 && nb[1] == 0) m_own = 0;
            else if (own_set) m_own = 1;
            if (rise[0] == 1)
                m_src = (wr_data[5] && (rsp_type == 2'd1 || rsp_type == 2'd2) && !rsp_hdr3) ? 1 : 0;
            if (wr_en)
                for (int k = 0; k < 4; k++) m_cfg[k] = wr_data[4+k];
            for (int k = 0; k < 4; k++) m_cmd[k] = nb[k];
        end
    end

    task automatic check(input string req, input string what, input int act, input int exp);
        n_chk++;
        if (act != exp) begin
            n_bad++;
            $display("FAIL %s %s actual=%0d expected=%0d at %0t", req, what, act, exp, $time);
        end
    endtask

    task automatic compare_all();
        check("R1", "upper bits", int'(rd_data[15:8]), 0);
        check("R2", "rx_ie bit7", int'(rd_data[7]), m_cfg[3]);
        check("R2", "tx_ie bit6", int'(rd_data[6]), m_cfg[2]);
        check("R2", "rsp_en bit5", int'(rd_data[5]), m_cfg[1]);
        check("R2", "crc_en bit4", int'(rd_data[4]), m_cfg[0]);
        check("R2", "cfg outputs", int'({rx_ie, tx_ie, crc_en}), m_cfg[3]*4 + m_cfg[2]*2 + m_cfg[0]);
        check("R4", "tx bit1", int'(rd_data[1]), m_cmd[1]);
        check("R8", "rsp bit0", int'(rd_data[0]), m_cmd[0]);
        check("R10", "rel bit2/rel_req", int'({rd_data[2], rel_req}), m_cmd[2]*3);
        check("R10", "brk bit3/brk_req", int'({rd_data[3], brk_req}), m_cmd[3]*3);
        check("R3", "tx_start", int'(tx_start), m_txs);
        check("R5", "tx_abort", int'(tx_abort), m_txa);
        check("R7", "rsp_start", int'(rsp_start), m_rss);
        check("R8", "rsp_abort", int'(rsp_abort), m_rsa);
        check("R6", "own_flag", int'(own_flag), m_own);
        check("R9", "rsp_src_reg", int'(rsp_src_reg), m_src);
    endtask

    task automatic cyc();
        @(negedge clk);
        compare_all();
        wr_en = 1'b0; tx_done = 1'b0; rsp_done = 1'b0; rel_done = 1'b0;
        brk_done = 1'b0; own_set = 1'b0;
    endtask

    task automatic wr(input logic [15:0] d);
        wr_en = 1'b1; wr_data = d;
        cyc();
    endtask

    initial begin
        #(200000 * 4);
        if (!finished) begin
            n_chk++; n_bad++;
            $display("FAIL watchdog expired actual=running expected=done");
            $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_bad);
            $finish;
        end
    end

    initial begin
        @(negedge clk); @(negedge clk);
        rst = 1'b0;
        check("R1", "reset rd_data", int'(rd_data), 0);
        check("R1", "reset strobes", int'({tx_start, tx_abort, rsp_start, rsp_abort, own_flag}), 0);

        wr(16'hFFF0);                 // R2, upper write bits ignored (R1)
        check("R1", "upper after write", int'(rd_data[15:8]), 0);
        check("R2", "cfg written", int'(rd_data[7:4]), 15);
        wr(16'h00F2);                 // R3 start
        check("R3", "tx_start pulse", int'(tx_start), 1);
        own_set = 1'b1; cyc();
        check("R6", "own set", int'(own_flag), 1);
        wr(16'h00F2);                 // R3 no restart
        check("R3", "no second start", int'(tx_start), 0);
        tx_done = 1'b1; cyc();        // R4, R6
        check("R4", "tx cleared", int'(rd_data[1]), 0);
        check("R6", "own cleared", int'(own_flag), 0);
        wr(16'h00F2);
        wr(16'h00F0);                 // R5 abort
        check("R5", "tx_abort pulse", int'(tx_abort), 1);
        wr(16'h00F0);
        check("R5", "no abort idle", int'(tx_abort), 0);
        tx_done = 1'b1; wr(16'h00F2); // R11 set collision
        check("R11", "set ignored", int'(rd_data[1]), 0);
        check("R11", "no start", int'(tx_start), 0);
        wr(16'h00F2);
        tx_done = 1'b1; own_set = 1'b1; wr(16'h00F0);  // R11 drop collision, R6 clear wins
        check("R11", "no abort", int'(tx_abort), 0);
        check("R6", "clear beats set", int'(own_flag), 0);
        rsp_type = 2'd1; rsp_hdr3 = 1'b0; wr(16'h00F1);
        check("R9", "source reg", int'(rsp_src_reg), 1);
        check("R8", "rsp_start", int'(rsp_start), 1);
        rsp_type = 2'd3; cyc();
        check("R9", "source held", int'(rsp_src_reg), 1);
        rsp_done = 1'b1; cyc();
        check("R8", "rsp cleared", int'(rd_data[0]), 0);
        wr(16'h00F1);
        check("R9", "type3 txbuf", int'(rsp_src_reg), 0);
        wr(16'h00F0);
        check("R8", "rsp_abort", int'(rsp_abort), 1);
        rsp_type = 2'd2; rsp_hdr3 = 1'b1; wr(16'h00F1);
        check("R9", "hdr3 txbuf", int'(rsp_src_reg), 0);
        rsp_hdr3 = 1'b0; wr(16'h00D0); wr(16'h00D1);
        check("R9", "disabled txbuf", int'(rsp_src_reg), 0);
        wr(16'h0000); wr(16'h0002);
        check("R7", "tx no rsp start", int'(rsp_start), 0);
        wr(16'h0008);
        check("R10", "brk_req", int'(brk_req), 1);
        brk_done = 1'b1; cyc();
        check("R10", "brk cleared", int'(brk_req), 0);
        wr(16'h0004);
        check("R10", "rel_req", int'(rel_req), 1);
        rel_done = 1'b1; cyc();
        check("R10", "rel cleared", int'(rel_req), 0);

        for (int n = 0; n < 4000; n++) begin
            wr_en    = ($urandom_range(0, 9) < 3);
            wr_data  = 16'($urandom);
            tx_done  = ($urandom_range(0, 9) < 2);
            rsp_done = ($urandom_range(0, 9) < 2);
            rel_done = ($urandom_range(0, 9) < 2);
            brk_done = ($urandom_range(0, 9) < 2);
            own_set  = ($urandom_range(0, 9) < 3);
            rsp_type = 2'($urandom);
            rsp_hdr3 = ($urandom_range(0, 3) == 0);
            cyc();
        end

        finished = 1'b1;
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_bad);
        $finish;
    end

endmodule